// File: doc/BRIEF.md
# Alert Pin Driver with Host Inactivity Watchdog

This block drives one status pin toward a host controller. A set of internal condition flags is gated by a per-flag enable mask and OR-combined. The result, together with a watchdog expiry flag, sets the pin. An input bit selects the pin's active level. The pin is registered, so a change on the inputs shows on the pin one clock later.

The block can also watch the host. After the first host command seen since reset, the watchdog counts millisecond ticks. If a set number of ticks pass with no further command (2000 by default, about two seconds), it raises the pin as a reset indication for the host. The indication stays up until the next command, which clears it and restarts the count.

While the device sleeps, the pin level, the counter and all watchdog state are frozen.

Top module: `alert_host_wdog`

## Requirements
- R1: While `rst_n` is low, `alert_pin` is 0. The watchdog is disarmed and its counter is zero.
- R2: With `sleep` low, if any bit of `cond & cond_en` is 1, the pin takes its active level at the next clock edge.
- R3: A condition bit whose enable bit is 0 has no effect on the pin.
- R4: With `pol_high` = 1 the active pin level is 1 and the idle level is 0. With `pol_high` = 0 the active level is 0 and the idle level is 1.
- R5: Before the first host command after reset, the watchdog never expires, however many ticks arrive.
- R6: Once armed and with `wdog_en` = 1, the watchdog expires on the TIMEOUT_TICKS-th tick after the last command, and not on an earlier tick. The pin is active from the following clock edge.
- R7: Every host command taken with `sleep` low restarts the tick count from zero.
- R8: After expiry the pin stays active while no command arrives and more ticks come. The next command clears the expiry, and the pin returns to idle one cycle later, provided no enabled condition is set.
- R9: With `wdog_en` = 0 the count is held at zero and any expiry is cleared, so the watchdog has no effect on the pin.
- R10: While `sleep` is 1, the pin, the tick count and the watchdog state keep their values. Ticks, commands and condition changes in those cycles are ignored.
- R11: When a command and a tick arrive in the same cycle, the command wins. The count restarts at zero and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cond | input | NUM_COND | Internal status condition flags |
| cond_en | input | NUM_COND | Per-condition enable mask |
| pol_high | input | 1 | 1: pin active high, 0: pin active low |
| wdog_en | input | 1 | Host watchdog enable |
| host_cmd | input | 1 | One-cycle pulse per host command received |
| sleep | input | 1 | Freeze request while the device sleeps |
| alert_pin | output | 1 | Alert / reset indication pin level |

## Verification
Two things can coincide: a host command and the millisecond tick that would otherwise bring the count to expiry. The bench provokes this by counting ticks up to TIMEOUT_TICKS-1 and then pulsing both inputs in one cycle. The command must win. A full TIMEOUT_TICKS further ticks are then needed before the pin goes active, and the bench checks the pin just before and just after that tick. A second case places a command inside a sleep window, where it must be lost and the count must continue unchanged after wake-up.

// File: rtl/alert_pkg.sv
package alert_pkg;

   // Selects how the gated conditions are reduced to one request.
   localparam int unsigned ALERT_COMBINE_FLAT = 0;
   localparam int unsigned ALERT_COMBINE_TREE = 1;

   // Pin level for a given request and polarity.
   function automatic logic pin_level(input logic request, input logic pol_high);
      return pol_high ? request : ~request;
   endfunction

endpackage

// File: rtl/alert_combine.sv
module alert_combine #(
   parameter int unsigned NUM_COND      = 8,
   parameter int unsigned COMBINE_STYLE = alert_pkg::ALERT_COMBINE_FLAT
) (
   input  logic [NUM_COND-1:0] cond,
   input  logic [NUM_COND-1:0] cond_en,
   output logic                any_active
);
   localparam int unsigned LEVELS = (NUM_COND > 1) ? $clog2(NUM_COND) : 0;
   localparam int unsigned PADDED = 1 << LEVELS;

   logic [NUM_COND-1:0] gated;
   assign gated = cond & cond_en;

   if (COMBINE_STYLE == alert_pkg::ALERT_COMBINE_FLAT) begin : g_flat
      assign any_active = |gated;
   end else begin : g_tree
      logic [PADDED-1:0] padded;
      assign padded = PADDED'(gated);
      for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
         logic [(PADDED >> lv)-1:0] v;
         if (lv == 0) begin : g_leaf
            assign v = padded;
         end else begin : g_node
            for (genvar k = 0; k < (PADDED >> lv); k++) begin : g_or
               assign v[k] = g_lvl[lv-1].v[2*k] | g_lvl[lv-1].v[2*k+1];
            end
         end
      end
      assign any_active = g_lvl[LEVELS].v[0];
   end

endmodule

// File: rtl/alert_wdog.sv
module alert_wdog #(
   parameter int unsigned TIMEOUT_TICKS = 2000
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             tick,
   input  logic                             host_cmd,
   input  logic                             wd_en,
   input  logic                             hold,
   output logic                             fired,
   output logic                             armed,
   output logic [$clog2(TIMEOUT_TICKS)-1:0] count
);
   localparam int unsigned CW   = $clog2(TIMEOUT_TICKS);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

   logic [CW-1:0] cnt_q;
   logic          fired_q;
   logic          armed_q;
   logic          counting;

   assign counting = armed_q & wd_en & tick & ~fired_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
         armed_q <= 1'b0;
      end else if (!hold) begin
         if (host_cmd) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            armed_q <= 1'b1;
         end else if (!wd_en) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
         end else if (counting) begin
            if (cnt_q == LAST) begin
               cnt_q   <= '0;
               fired_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign fired = fired_q;
   assign armed = armed_q;
   assign count = cnt_q;

endmodule

// File: rtl/alert_outreg.sv
module alert_outreg #(
   parameter logic RESET_PIN_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic request,
   input  logic pol_high,
   input  logic hold,
   output logic pin
);
   logic pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= RESET_PIN_LEVEL;
      end else if (!hold) begin
         pin_q <= alert_pkg::pin_level(request, pol_high);
      end
   end

   assign pin = pin_q;

endmodule

// File: rtl/alert_host_wdog.sv
module alert_host_wdog #(
   parameter int unsigned NUM_COND        = 8,
   parameter int unsigned TIMEOUT_TICKS   = 2000,
   parameter int unsigned COMBINE_STYLE   = alert_pkg::ALERT_COMBINE_FLAT,
   parameter logic        RESET_PIN_LEVEL = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ms_tick,
   input  logic [NUM_COND-1:0] cond,
   input  logic [NUM_COND-1:0] cond_en,
   input  logic                pol_high,
   input  logic                wdog_en,
   input  logic                host_cmd,
   input  logic                sleep,
   output logic                alert_pin
);
   localparam int unsigned CW = $clog2(TIMEOUT_TICKS);

   if (NUM_COND < 1) begin : g_bad_cond
      $error("alert_host_wdog: NUM_COND must be at least 1");
   end
   if (TIMEOUT_TICKS < 2) begin : g_bad_timeout
      $error("alert_host_wdog: TIMEOUT_TICKS must be at least 2");
   end
   if (COMBINE_STYLE > alert_pkg::ALERT_COMBINE_TREE) begin : g_bad_style
      $error("alert_host_wdog: unknown COMBINE_STYLE");
   end

   logic          cond_any;
   logic          wd_fired;
   logic          wd_armed;
   logic [CW-1:0] wd_cnt;
   logic          request;

   alert_combine #(
      .NUM_COND      (NUM_COND),
      .COMBINE_STYLE (COMBINE_STYLE)
   ) u_combine (
      .cond       (cond),
      .cond_en    (cond_en),
      .any_active (cond_any)
   );

   alert_wdog #(
      .TIMEOUT_TICKS (TIMEOUT_TICKS)
   ) u_wdog (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (ms_tick),
      .host_cmd (host_cmd),
      .wd_en    (wdog_en),
      .hold     (sleep),
      .fired    (wd_fired),
      .armed    (wd_armed),
      .count    (wd_cnt)
   );

   assign request = cond_any | wd_fired;

   alert_outreg #(
      .RESET_PIN_LEVEL (RESET_PIN_LEVEL)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .request  (request),
      .pol_high (pol_high),
      .hold     (sleep),
      .pin      (alert_pin)
   );

endmodule

// File: rtl/alert_host_wdog_chk.sv
module alert_host_wdog_chk #(
   parameter int unsigned NUM_COND      = 8,
   parameter int unsigned TIMEOUT_TICKS = 2000
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [NUM_COND-1:0]              cond,
   input logic [NUM_COND-1:0]              cond_en,
   input logic                             pol_high,
   input logic                             wdog_en,
   input logic                             host_cmd,
   input logic                             sleep,
   input logic                             alert_pin,
   input logic                             wd_fired,
   input logic                             wd_armed,
   input logic [$clog2(TIMEOUT_TICKS)-1:0] wd_cnt
);
   assert_active_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && pol_high && (|(cond & cond_en))) |=> alert_pin);

   assert_active_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !pol_high && (|(cond & cond_en))) |=> !alert_pin);

   assert_no_fire_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_armed |-> !wd_fired);

   assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_cnt <= ($clog2(TIMEOUT_TICKS))'(TIMEOUT_TICKS - 1));

   assert_cmd_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cmd && !sleep) |=> (wd_cnt == '0 && !wd_fired && wd_armed));

   assert_fired_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_fired && !host_cmd && !sleep && wdog_en) |=> wd_fired);

   assert_disabled_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdog_en && !sleep) |=> (!wd_fired && wd_cnt == '0));

   assert_sleep_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(alert_pin));

   assert_sleep_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(wd_cnt) && $stable(wd_fired) && $stable(wd_armed)));

endmodule

bind alert_host_wdog alert_host_wdog_chk #(
   .NUM_COND      (NUM_COND),
   .TIMEOUT_TICKS (TIMEOUT_TICKS)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cond      (cond),
   .cond_en   (cond_en),
   .pol_high  (pol_high),
   .wdog_en   (wdog_en),
   .host_cmd  (host_cmd),
   .sleep     (sleep),
   .alert_pin (alert_pin),
   .wd_fired  (wd_fired),
   .wd_armed  (wd_armed),
   .wd_cnt    (wd_cnt)
);

// File: tb/test_alert_host_wdog.sv
module test_alert_host_wdog;
   localparam int unsigned N = 6;
   localparam int unsigned T = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ms_tick = 1'b0;
   logic [N-1:0] cond = '0;
   logic [N-1:0] cond_en = '0;
   logic         pol_high = 1'b1;
   logic         wdog_en = 1'b1;
   logic         host_cmd = 1'b0;
   logic         sleep = 1'b0;
   logic         alert_pin;

   int total = 0;
   int bad = 0;

   // reference state
   logic m_pin = 1'b0;
   logic m_fired = 1'b0;
   logic m_armed = 1'b0;
   int   m_cnt = 0;

   always #4 clk = ~clk;

   alert_host_wdog #(
      .NUM_COND      (N),
      .TIMEOUT_TICKS (T),
      .COMBINE_STYLE (alert_pkg::ALERT_COMBINE_TREE)
   ) i_alert_host_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .ms_tick   (ms_tick),
      .cond      (cond),
      .cond_en   (cond_en),
      .pol_high  (pol_high),
      .wdog_en   (wdog_en),
      .host_cmd  (host_cmd),
      .sleep     (sleep),
      .alert_pin (alert_pin)
   );

   function automatic logic exp_pin(input logic req, input logic pol);
      return pol ? req : ~req;
   endfunction

   task automatic check(input logic act, input logic exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: alert_pin actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      logic req;
      if (sleep) return;
      req   = (|(cond & cond_en)) | m_fired;
      m_pin = exp_pin(req, pol_high);
      if (host_cmd) begin
         m_cnt = 0; m_fired = 1'b0; m_armed = 1'b1;
      end else if (!wdog_en) begin
         m_cnt = 0; m_fired = 1'b0;
      end else if (m_armed && ms_tick && !m_fired) begin
         if (m_cnt == T - 1) begin
            m_cnt = 0; m_fired = 1'b1;
         end else begin
            m_cnt++;
         end
      end
   endtask

   task automatic cycle(input logic tk, input logic cmd, input logic slp, input string tag);
      ms_tick = tk; host_cmd = cmd; sleep = slp;
      @(posedge clk);
      model_step();
      #1;
      check(alert_pin, m_pin, tag);
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 1'b0, tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      summary();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      check(alert_pin, 1'b0, "R1 pin during reset");
      rst_n = 1'b1;
      #1;
      check(alert_pin, 1'b0, "R1 pin after reset release");

      // R5: no arming without a command
      ticks(3 * T, "R5 unarmed ticks");
      check(alert_pin, 1'b0, "R5 no expiry before first command");

      // R6: exact expiry point
      cycle(1'b0, 1'b1, 1'b0, "R6 first command");
      ticks(T - 1, "R6 counting");
      idle(2, "R6 idle");
      check(alert_pin, 1'b0, "R6 not expired after T-1 ticks");
      ticks(1, "R6 final tick");
      idle(1, "R6 idle");
      check(alert_pin, 1'b1, "R6 expired after T ticks");

      // R8: sticky until command
      ticks(5, "R8 extra ticks");
      check(alert_pin, 1'b1, "R8 stays active");
      cycle(1'b0, 1'b1, 1'b0, "R8 clearing command");
      idle(1, "R8 idle");
      check(alert_pin, 1'b0, "R8 cleared by command");

      // R7: command restarts count
      ticks(T - 2, "R7 partial count");
      cycle(1'b0, 1'b1, 1'b0, "R7 restart");
      ticks(T - 1, "R7 recount");
      idle(1, "R7 idle");
      check(alert_pin, 1'b0, "R7 restarted count not expired");
      ticks(1, "R7 final tick");
      idle(1, "R7 idle");
      check(alert_pin, 1'b1, "R7 expired after full recount");
      cycle(1'b0, 1'b1, 1'b0, "R7 clear");
      idle(1, "R7 idle");

      // R11: command and tick together
      ticks(T - 1, "R11 count to edge");
      cycle(1'b1, 1'b1, 1'b0, "R11 command with tick");
      ticks(T - 1, "R11 recount");
      idle(1, "R11 idle");
      check(alert_pin, 1'b0, "R11 coincident tick not counted");
      ticks(1, "R11 final tick");
      idle(1, "R11 idle");
      check(alert_pin, 1'b1, "R11 expiry after full recount");

      // R9: disable clears and blocks
      wdog_en = 1'b0;
      idle(2, "R9 idle");
      check(alert_pin, 1'b0, "R9 disable clears expiry");
      ticks(3 * T, "R9 disabled ticks");
      check(alert_pin, 1'b0, "R9 no expiry while disabled");
      wdog_en = 1'b1;
      cycle(1'b0, 1'b1, 1'b0, "R9 rearm");
      idle(1, "R9 idle");

      // R10: sleep freezes everything, command in sleep lost
      ticks(T - 1, "R10 count");
      cond = '1; cond_en = '1;
      for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 1'b1, "R10 sleeping ticks");
      cycle(1'b0, 1'b1, 1'b1, "R10 command in sleep");
      check(alert_pin, 1'b0, "R10 pin frozen in sleep");
      cond = '0;
      idle(2, "R10 awake");
      check(alert_pin, 1'b0, "R10 count frozen in sleep");
      ticks(1, "R10 final tick");
      idle(1, "R10 idle");
      check(alert_pin, 1'b1, "R10 count resumed, sleep command ignored");

      // R3 / R2: masking
      wdog_en = 1'b0;
      cond = 6'b101010; cond_en = 6'b010101;
      idle(2, "R3 masked");
      check(alert_pin, 1'b0, "R3 disabled conditions ignored");
      cond_en = 6'b010111;
      idle(1, "R2 enabled");
      check(alert_pin, 1'b1, "R2 enabled condition drives pin");

      // R4: polarity
      pol_high = 1'b0; cond = '0;
      idle(2, "R4 idle low");
      check(alert_pin, 1'b1, "R4 idle level with active-low");
      cond = 6'b000001; cond_en = 6'b000001;
      idle(1, "R4 active low");
      check(alert_pin, 1'b0, "R4 active level with active-low");
      pol_high = 1'b1; wdog_en = 1'b1;

      // random mix
      for (int i = 0; i < 4000; i++) begin
         if (i % 64 == 0) begin
            pol_high = ($urandom % 4) != 0;
            wdog_en  = ($urandom % 5) != 0;
         end
         if (i % 8 == 0) begin
            cond    = N'($urandom);
            cond_en = ($urandom % 3 == 0) ? N'($urandom) : '0;
         end
         cycle(1'($urandom % 2), ($urandom % 48) == 0, ($urandom % 16) == 0,
               "R2 R4 R6 R7 R8 R9 R10 R11 random");
      end

      summary();
   end

endmodule